// File: doc/BRIEF.md
# Prescaled Timer/Counter with Compare Outputs and Capture

This block is a 32-bit up-counter fed through a 32-bit prescaler. In timer mode the prescaler advances on every clock; in counter mode it advances only on the selected edges of an external count input, after that input has been brought into the clock domain. Each time the prescaler wraps, the main counter steps by one.

Four compare channels watch the counter. Each channel can flag an interrupt, return the counter to zero, or halt the counter when the counter reaches its compare value, in any combination. Each channel also drives one output pin that is set low, set high, toggled or left alone on a hit. Two capture channels copy the counter when their input shows a selected edge, and can flag an interrupt. Software reaches everything through a small word-wide register port with a combinational read path. Interrupt flags are cleared by writing ones.

Top module: `matchTimer`

## Requirements
- R1: With the enable bit (CTRL bit 0) set and timer mode selected (CTRL bit 1 = 0), the counter steps once every P+1 clocks, where P is the prescale register. With the enable bit clear, the counter holds its value.
- R2: Writing the prescale register (address 1) or the count register (address 2) clears the prescaler phase. A write to the count register loads the counter directly.
- R3: In counter mode (CTRL bit 1 = 1), the prescaler advances once per edge of `countIn`, after two synchronizing flops. CTRL bit 2 selects rising edges and bit 3 selects falling edges, and both may be set at once.
- R4: A compare hit on a channel whose stop bit is set (MCTL bit 3i+2) clears the enable bit, so the counter rests at the compare value.
- R5: When the counter equals the compare value of a channel whose reset bit is set (MCTL bit 3i+1), the next step loads zero instead of the incremented value.
- R6: A hit happens when a step moves the counter onto compare value i (addresses 8+i). With MCTL bit 3i set, the hit sets STATUS bit i. `irq` is the OR of all STATUS bits.
- R7: On a hit, `matchOut[i]` follows the action in MCTL bits [16+2i+1:16+2i]: 0 leaves it unchanged, 1 drives it low, 2 drives it high, 3 toggles it.
- R8: Capture channel j (registers at addresses 12+j) latches the counter on a rising edge of `capIn[j]` when CCTL bit 3j is set, and on a falling edge when CCTL bit 3j+1 is set. Data is taken on the third clock edge after the input changes, using the counter value held just before that edge. An edge that is not selected leaves the capture register unchanged.
- R9: A capture with CCTL bit 3j+2 set sets STATUS bit 4+j. A capture with that bit clear sets no flag.
- R10: Writing STATUS (address 3) clears each bit written as one. Bits written as zero stay unchanged.
- R11: After reset, every register, the counter, `matchOut` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| countIn | input | 1 | External count source (asynchronous) |
| capIn | input | 2 | Capture inputs (asynchronous) |
| matchOut | output | 4 | Compare-driven output pins |
| irq | output | 1 | Interrupt request, OR of the status flags |

## Verification
A wrong prescaler phase or a missed step shows up at once as a counter read that differs from floor(cycles/(P+1)). A bad reset-on-compare path shows up within one period as a count that is not K mod (M+1). A lost or doubled compare hit flips the parity of a toggling output, which stays wrong on the pin until the next hit. A capture taken a cycle early or late differs by one from the value that the bench predicts from the running count.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int NUM_MATCH = 4;
  localparam int NUM_CAP   = 2;
  localparam int ADDR_W    = 4;
  localparam int CTRL_W    = 4;
  localparam int MCTL_W    = 16 + 2 * NUM_MATCH;
  localparam int CCTL_W    = 3 * NUM_CAP;
  localparam int STAT_W    = NUM_MATCH + NUM_CAP;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRE    = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT    = 4'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCTL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CCTL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd8;
  localparam logic [ADDR_W-1:0] A_CAP0   = 4'd12;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'd0,
    OUT_LOW    = 2'd1,
    OUT_HIGH   = 2'd2,
    OUT_TOGGLE = 2'd3
  } outAct_t;

  typedef struct packed {
    logic                 advance;
    logic                 cntWrite;
    logic [NUM_MATCH-1:0] matchWrite;
    logic [NUM_CAP-1:0]   capture;
  } strb_t;
endpackage

// File: rtl/mtCtrl.sv
module mtCtrl
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CNT_W-1:0]       wrData,
  input  logic                   countIn,
  input  logic [NUM_CAP-1:0]     capIn,
  input  logic [NUM_MATCH-1:0]   matchEv,
  output strb_t                  strb,
  output logic [CTRL_W-1:0]      ctrlReg,
  output logic [CNT_W-1:0]       prescale,
  output logic [MCTL_W-1:0]      matchCtl,
  output logic [CCTL_W-1:0]      capCtl,
  output logic [STAT_W-1:0]      status,
  output logic [NUM_MATCH-1:0]   rstEn,
  output logic [2*NUM_MATCH-1:0] outActs,
  output logic                   irq
);
  localparam int SYN_W = NUM_CAP + 1;

  logic [SYN_W-1:0] syncA, syncB, syncPrev, riseV, fallV;
  logic [CNT_W-1:0] preCnt;
  logic [NUM_MATCH-1:0] stopEn, irqEn;
  logic [STAT_W-1:0] setV, clrV;
  logic countEdge, tick, wrCtrl, wrPre, wrCnt, wrStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= {countIn, capIn};
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign riseV = syncB & ~syncPrev;
  assign fallV = ~syncB & syncPrev;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrPre  = wrEn && (addr == A_PRE);
  assign wrCnt  = wrEn && (addr == A_CNT);
  assign wrStat = wrEn && (addr == A_STAT);

  assign countEdge = (ctrlReg[2] & riseV[NUM_CAP]) | (ctrlReg[3] & fallV[NUM_CAP]);
  assign tick      = ctrlReg[0] & (ctrlReg[1] ? countEdge : 1'b1);

  assign strb.advance  = tick && (preCnt == prescale);
  assign strb.cntWrite = wrCnt;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_mdec
    assign irqEn[i]              = matchCtl[3*i];
    assign rstEn[i]              = matchCtl[3*i+1];
    assign stopEn[i]             = matchCtl[3*i+2];
    assign outActs[2*i +: 2]     = matchCtl[16+2*i +: 2];
    assign strb.matchWrite[i]    = wrEn && (addr == A_MATCH0 + ADDR_W'(i));
    assign setV[i]               = matchEv[i] & irqEn[i];
  end

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cdec
    assign strb.capture[j] = (riseV[j] & capCtl[3*j]) | (fallV[j] & capCtl[3*j+1]);
    assign setV[NUM_MATCH+j] = strb.capture[j] & capCtl[3*j+2];
  end

  assign clrV = wrStat ? wrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      ctrlReg  <= '0;
      prescale <= '0;
      matchCtl <= '0;
      capCtl   <= '0;
      status   <= '0;
    end else begin
      if (wrPre || wrCnt)       preCnt <= '0;
      else if (strb.advance)    preCnt <= '0;
      else if (tick)            preCnt <= preCnt + CNT_W'(1);

      if (wrCtrl)               ctrlReg <= wrData[CTRL_W-1:0];
      else if (|(matchEv & stopEn)) ctrlReg[0] <= 1'b0;

      if (wrPre)                prescale <= wrData;
      if (wrEn && addr == A_MCTL) matchCtl <= wrData[MCTL_W-1:0];
      if (wrEn && addr == A_CCTL) capCtl   <= wrData[CCTL_W-1:0];

      status <= (status & ~clrV) | setV;
    end
  end

  assign irq = |status;

  // R2
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= prescale);

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_chk
    // R4
    stop_clears_en_chk: assert property (@(posedge clk) disable iff (!rstN)
      (matchEv[i] && stopEn[i] && !wrCtrl) |=> !ctrlReg[0]);
    // R6
    match_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (matchEv[i] && irqEn[i]) |=> status[i]);
  end
endmodule

// File: rtl/mtDatapath.sv
module mtDatapath
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strb_t                             strb,
  input  logic [CNT_W-1:0]                  wrData,
  input  logic [NUM_MATCH-1:0]              rstEn,
  input  logic [2*NUM_MATCH-1:0]            outActs,
  output logic [CNT_W-1:0]                  cnt,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]   matchVal,
  output logic [NUM_CAP-1:0][CNT_W-1:0]     capVal,
  output logic [NUM_MATCH-1:0]              matchEv,
  output logic [NUM_MATCH-1:0]              matchOut
);
  logic [NUM_MATCH-1:0] rstHit;
  logic [CNT_W-1:0] nextCnt;

  assign nextCnt = (|rstHit) ? '0 : cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.cntWrite) cnt <= wrData;
    else if (strb.advance)  cnt <= nextCnt;
  end

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    outAct_t act;
    assign act       = outAct_t'(outActs[2*i +: 2]);
    assign rstHit[i] = rstEn[i] && (cnt == matchVal[i]);
    assign matchEv[i] = strb.advance && !strb.cntWrite && (nextCnt == matchVal[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchVal[i] <= '0;
        matchOut[i] <= 1'b0;
      end else begin
        if (strb.matchWrite[i]) matchVal[i] <= wrData;
        if (matchEv[i]) begin
          case (act)
            OUT_LOW:    matchOut[i] <= 1'b0;
            OUT_HIGH:   matchOut[i] <= 1'b1;
            OUT_TOGGLE: matchOut[i] <= ~matchOut[i];
            default:    matchOut[i] <= matchOut[i];
          endcase
        end
      end
    end

    // R5
    reset_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.advance && !strb.cntWrite && rstEn[i] && cnt == matchVal[i]) |=> (cnt == '0));
  end

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                capVal[j] <= '0;
      else if (strb.capture[j]) capVal[j] <= cnt;
    end

    // R8
    capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.capture[j] |=> (capVal[j] == $past(cnt)));
  end

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.cntWrite) |=> $stable(cnt));
endmodule

// File: rtl/matchTimer.sv
module matchTimer
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CNT_W-1:0]     wrData,
  output logic [CNT_W-1:0]     rdData,
  input  logic                 countIn,
  input  logic [NUM_CAP-1:0]   capIn,
  output logic [NUM_MATCH-1:0] matchOut,
  output logic                 irq
);
  strb_t strb;
  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0] prescale, cnt;
  logic [MCTL_W-1:0] matchCtl;
  logic [CCTL_W-1:0] capCtl;
  logic [STAT_W-1:0] status;
  logic [NUM_MATCH-1:0] rstEn, matchEv;
  logic [2*NUM_MATCH-1:0] outActs;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVal;
  logic [NUM_CAP-1:0][CNT_W-1:0] capVal;

  mtCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .countIn(countIn), .capIn(capIn), .matchEv(matchEv), .strb(strb),
    .ctrlReg(ctrlReg), .prescale(prescale), .matchCtl(matchCtl), .capCtl(capCtl),
    .status(status), .rstEn(rstEn), .outActs(outActs), .irq(irq)
  );

  mtDatapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rstEn(rstEn),
    .outActs(outActs), .cnt(cnt), .matchVal(matchVal), .capVal(capVal),
    .matchEv(matchEv), .matchOut(matchOut)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL: rdData[CTRL_W-1:0] = ctrlReg;
      A_PRE:  rdData = prescale;
      A_CNT:  rdData = cnt;
      A_STAT: rdData[STAT_W-1:0] = status;
      A_MCTL: rdData[MCTL_W-1:0] = matchCtl;
      A_CCTL: rdData[CCTL_W-1:0] = capCtl;
      default: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (addr == A_MATCH0 + ADDR_W'(i)) rdData = matchVal[i];
        for (int j = 0; j < NUM_CAP; j++)
          if (addr == A_CAP0 + ADDR_W'(j)) rdData = capVal[j];
      end
    endcase
  end
endmodule

// File: tb/matchTimer_test.sv
module matchTimer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic countIn = 1'b0;
  logic [1:0] capIn = 2'b00;
  logic [3:0] matchOut;
  logic irq;
  int nTests = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  matchTimer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .countIn(countIn), .capIn(capIn), .matchOut(matchOut), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic setup(input logic [31:0] pre, input logic [31:0] c0);
    wr(4'd0, 32'd0);
    wr(4'd1, pre);
    wr(4'd2, c0);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(4'd0, v); check("R11 ctrl", v, 0);
    rd(4'd2, v); check("R11 count", v, 0);
    rd(4'd3, v); check("R11 status", v, 0);
    check("R11 matchOut", {28'd0, matchOut}, 0);
    check("R11 irq", {31'd0, irq}, 0);

    // R1 R2 prescale sweep in timer mode
    for (int p = 0; p < 4; p++) begin
      for (int k = 5; k < 14; k += 4) begin
        setup(p, 0);
        wr(4'd0, 32'd1);
        repeat (k) @(negedge clk);
        rd(4'd2, v); check("R1 R2 prescaled count", v, k / (p + 1));
        wr(4'd0, 32'd0);
        rd(4'd2, c);
        repeat (6) @(negedge clk);
        rd(4'd2, v); check("R1 hold when disabled", v, c);
      end
    end

    // R5 R7 reset on match with toggle output on channel 0
    for (int m = 1; m < 5; m++) begin
      for (int k = 3; k < 12; k += 3) begin
        logic b;
        int hits;
        wr(4'd4, 32'h2 | (32'd3 << 16));
        wr(4'd8, m);
        setup(0, 0);
        b = matchOut[0];
        wr(4'd0, 32'd1);
        repeat (k) @(negedge clk);
        hits = (k >= m) ? (k - m) / (m + 1) + 1 : 0;
        rd(4'd2, v); check("R5 wrap count", v, k % (m + 1));
        check("R7 toggle parity", {31'd0, matchOut[0]}, {31'd0, b ^ hits[0]});
        wr(4'd0, 32'd0);
      end
    end

    // R4 R6 stop on match with interrupt, channel 1
    wr(4'd4, (32'd1 << 5) | (32'd1 << 3));
    wr(4'd9, 32'd4);
    wr(4'd3, 32'h3F);
    setup(0, 0);
    wr(4'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(4'd2, v); check("R4 counter rests at match", v, 4);
    rd(4'd0, v); check("R4 enable cleared", v & 32'd1, 0);
    rd(4'd3, v); check("R6 status bit1", v, 32'h2);
    check("R6 irq high", {31'd0, irq}, 1);
    wr(4'd3, 32'h0);
    rd(4'd3, v); check("R10 zero write keeps flag", v, 32'h2);
    wr(4'd3, 32'h2);
    rd(4'd3, v); check("R10 one write clears", v, 0);
    check("R10 irq low", {31'd0, irq}, 0);

    // R7 set high / set low actions on channels 2 and 3
    wr(4'd4, (32'd2 << 20) | (32'd2 << 22));
    wr(4'd10, 32'd2);
    wr(4'd11, 32'd3);
    setup(0, 0);
    wr(4'd0, 32'd1);
    repeat (5) @(negedge clk);
    check("R7 set high", {30'd0, matchOut[3:2]}, 3);
    wr(4'd4, 32'd1 << 20);
    setup(0, 0);
    wr(4'd0, 32'd1);
    repeat (5) @(negedge clk);
    check("R7 set low and no change", {30'd0, matchOut[3:2]}, 2);
    wr(4'd4, 32'd0);

    // R3 counter mode, edge selections and prescale
    for (int p = 0; p < 2; p++) begin
      for (int s = 1; s < 4; s++) begin
        int edges;
        setup(p, 0);
        wr(4'd0, 32'd3 | (s << 2));
        for (int n = 0; n < 5; n++) begin
          countIn = 1'b1; repeat (2) @(negedge clk);
          countIn = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        edges = (s == 3) ? 10 : 5;
        rd(4'd2, v); check("R3 counted edges", v, edges / (p + 1));
      end
    end

    // R8 R9 capture channels
    wr(4'd5, 32'd5 | 32'd16);
    setup(0, 100);
    wr(4'd3, 32'h3F);
    wr(4'd0, 32'd1);
    for (int d = 0; d < 4; d++) begin
      logic [31:0] held;
      repeat (d) @(negedge clk);
      rd(4'd2, c);
      capIn[0] = 1'b1;
      repeat (3) @(negedge clk);
      rd(4'd12, v); check("R8 rise capture", v, c + 2);
      held = v;
      capIn[0] = 1'b0;
      repeat (3) @(negedge clk);
      rd(4'd12, v); check("R8 unselected edge ignored", v, held);
      capIn[1] = 1'b1;
      repeat (3 + d) @(negedge clk);
      rd(4'd2, c);
      capIn[1] = 1'b0;
      repeat (3) @(negedge clk);
      rd(4'd13, v); check("R8 fall capture", v, c + 2);
    end
    rd(4'd3, v); check("R9 capture flags", v, 32'h10);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule